// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block is a two-wire bus slave that fronts a 256-byte array. A fast system clock oversamples the SCL and SDA lines. Edge logic detects clock edges and the START and STOP conditions. A controller then decodes the slave byte, takes a word address, and serves byte and page writes as well as random, current and sequential reads. The response to SDA is an open-drain pull-down enable. The surrounding pad logic turns it into a low level on the wire.

Write data is collected in a 16-entry page buffer. The buffer is copied into the array only when a STOP closes the write. A busy window of `WR_CYCLES` system clocks then follows, and the slave ignores the bus during that window. A master can therefore poll for completion by sending the slave byte until it is acknowledged. A write-protect pin, a low-supply flag, a per-byte write-allow input and an acknowledge veto come from neighbouring blocks. The controller applies them at fixed points of a transfer.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After reset every one of the 256 locations reads 0xFF, the SDA pull-down is released and the busy flag is low.
- R2: The slave acknowledges a slave byte only when bits [7:4] are 1010 and bits [3:1] equal `strap_i`. Bit 0 selects read (1) or write (0). Any other slave byte gets no acknowledge.
- R3: SDA is sampled on SCL rising edges. The slave changes its SDA drive only after SCL falls. Every byte is followed by a ninth clock, during which an accepted byte is acknowledged by pulling SDA low. Read data is sent MSB first.
- R4: A write is programmed into the array only when STOP ends it. `busy_o` then stays high for exactly `WR_CYCLES` system clocks.
- R5: While `busy_o` is high the slave acknowledges nothing, not even its own slave byte.
- R6: After each accepted write data byte only address bits [3:0] increment and bits [7:4] stay fixed. More than 16 bytes wrap within the page, and later bytes overwrite earlier ones.
- R7: A read returns the byte at the current address. Each master acknowledge (SDA low on the ninth clock) advances the address by one and sends the next byte. The address runs through all 256 locations and wraps from 0xFF to 0x00.
- R8: A current read (slave byte with bit 0 = 1 and no word address) returns the byte at the last read address plus one.
- R9: A master not-acknowledge (SDA high on the ninth clock) makes the slave release SDA and send no more data until the next START.
- R10: If WP is high on the clock that latches the last data byte bit, that byte is not acknowledged. If WP goes high at any time after the first data bit has been latched, the pending write is dropped. If WP is high during the busy window, the write is abandoned: busy falls on the next cycle and the array keeps its old contents.
- R11: A START followed directly by a STOP while a write is being entered cancels that write, and no busy window starts.
- R12: If `lowvcc_i` is high when STOP ends a write, the page buffer is discarded and no busy window starts.
- R13: If `prot_allow_i` is low when a data byte completes, that byte is not acknowledged and not stored. `ack_veto_i` high suppresses every acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level as seen on the wire |
| strap_i | input | 3 | Pin-strapped device select bits |
| wp_i | input | 1 | Write protect; high blocks and aborts writes |
| lowvcc_i | input | 1 | Low supply flag; high blocks programming at STOP |
| prot_allow_i | input | 1 | Write permission for the byte at `prot_addr_o` |
| ack_veto_i | input | 1 | High forces not-acknowledge |
| sda_oe_o | output | 1 | High pulls SDA low |
| busy_o | output | 1 | High during the internal write cycle |
| prot_addr_o | output | 8 | Address the next write byte would land on |

## Verification
The properties assume that each SCL phase spans several system clocks, more than the two-stage synchronizer plus one edge register. They also assume that SDA changes only while SCL is low, except for START and STOP, and that WP and the low-supply flag are synchronous to `clk`. The bench drives every bus phase for six system clocks. The master releases SDA on every ninth clock and read bit it expects from the slave, so the wired-AND bus has only one driver at a time. The protection inputs are changed only between bytes while SCL is low.

// File: rtl/eeprom_slave_pkg.sv
package eeprom_slave_pkg;
    localparam int ADDR_W     = 8;
    localparam int PAGE_W     = 4;
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int BUSY_W     = 20;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DEV,
        S_WADDR,
        S_WDATA,
        S_ACK,
        S_RDATA,
        S_RACK
    } st_e;

    typedef struct packed {
        st_e                             st;
        st_e                             nxt;
        logic [3:0]                      cnt;
        logic [7:0]                      sr;
        logic [7:0]                      tx;
        logic [ADDR_W-1:0]               ptr;
        logic                            ack;
        logic                            mack;
        logic                            wp_hit;
        logic [PAGE_BYTES-1:0]           vld;
        logic [PAGE_BYTES-1:0][7:0]      pbuf;
        logic [BUSY_W-1:0]               busy;
    } ctl_t;
endpackage

// File: rtl/eeprom_line_sync.sv
module eeprom_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s_o,
    output logic sda_s_o,
    output logic rise_o,
    output logic fall_o,
    output logic start_o,
    output logic stop_o
);
    logic [STAGES-1:0] scl_q;
    logic [STAGES-1:0] sda_q;
    logic              scl_l_q;
    logic              sda_l_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q   <= '1;
            sda_q   <= '1;
            scl_l_q <= 1'b1;
            sda_l_q <= 1'b1;
        end else begin
            scl_q   <= {scl_q[STAGES-2:0], scl_i};
            sda_q   <= {sda_q[STAGES-2:0], sda_i};
            scl_l_q <= scl_q[STAGES-1];
            sda_l_q <= sda_q[STAGES-1];
        end
    end

    assign scl_s_o = scl_q[STAGES-1];
    assign sda_s_o = sda_q[STAGES-1];
    assign rise_o  = scl_s_o & ~scl_l_q;
    assign fall_o  = ~scl_s_o & scl_l_q;
    assign start_o = scl_s_o & scl_l_q & sda_l_q & ~sda_s_o;
    assign stop_o  = scl_s_o & scl_l_q & ~sda_l_q & sda_s_o;
endmodule

// File: rtl/eeprom_page_array.sv
module eeprom_page_array #(
    parameter int AW = 8,
    parameter int PW = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         commit_i,
    input  logic [AW-PW-1:0]             page_i,
    input  logic [(1<<PW)-1:0]           mask_i,
    input  logic [(1<<PW)-1:0][7:0]      data_i,
    input  logic [AW-1:0]                rd_addr_i,
    output logic [7:0]                   rd_data_o
);
    localparam int DEPTH = 1 << AW;
    localparam int PB    = 1 << PW;

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
        end else if (commit_i) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (page_i == (AW-PW)'(i >> PW) && mask_i[i % PB])
                    mem_q[i] <= data_i[i % PB];
            end
        end
    end

    assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
    import eeprom_slave_pkg::*;
#(
    parameter logic [3:0] DEV_TYPE    = 4'b1010,
    parameter int         WR_CYCLES   = 100,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [2:0]        strap_i,
    input  logic              wp_i,
    input  logic              lowvcc_i,
    input  logic              prot_allow_i,
    input  logic              ack_veto_i,
    output logic              sda_oe_o,
    output logic              busy_o,
    output logic [ADDR_W-1:0] prot_addr_o
);
    ctl_t       q, d;
    logic       scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
    logic [7:0] rd_data;
    logic       commit;
    logic       data_started;
    logic       in_write;

    eeprom_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .scl_s_o (scl_s),
        .sda_s_o (sda_s),
        .rise_o  (scl_rise),
        .fall_o  (scl_fall),
        .start_o (start_evt),
        .stop_o  (stop_evt)
    );

    eeprom_page_array #(.AW(ADDR_W), .PW(PAGE_W)) u_arr (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit_i  (commit),
        .page_i    (q.ptr[ADDR_W-1:PAGE_W]),
        .mask_i    (q.vld),
        .data_i    (q.pbuf),
        .rd_addr_i (q.ptr),
        .rd_data_o (rd_data)
    );

    assign commit       = (q.busy == BUSY_W'(1)) && !wp_i;
    assign data_started = (q.cnt != 4'd0) || (|q.vld);
    assign in_write     = (q.st == S_WDATA) || (q.st == S_ACK && q.nxt == S_WDATA);

    always_comb begin
        d = q;
        if (q.busy != '0) begin
            // internal write cycle: bus is ignored, WP aborts
            d.st = S_IDLE;
            if (wp_i) begin
                d.busy = '0;
                d.vld  = '0;
            end else begin
                d.busy = q.busy - BUSY_W'(1);
                if (q.busy == BUSY_W'(1)) d.vld = '0;
            end
        end else if (stop_evt) begin
            d.st = S_IDLE;
            if ((|q.vld) && !lowvcc_i) d.busy = BUSY_W'(WR_CYCLES);
            else                       d.vld  = '0;
        end else if (start_evt) begin
            d.st     = S_DEV;
            d.cnt    = '0;
            d.vld    = '0;
            d.wp_hit = 1'b0;
        end else begin
            if (in_write && wp_i && data_started) begin
                d.wp_hit = 1'b1;
                d.vld    = '0;
            end
            case (q.st)
                S_DEV, S_WADDR, S_WDATA: begin
                    if (scl_rise) begin
                        d.sr  = {q.sr[6:0], sda_s};
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt == 4'd8) begin
                        d.cnt = '0;
                        d.st  = S_ACK;
                        d.ack = 1'b0;
                        d.nxt = S_IDLE;
                        if (q.st == S_DEV) begin
                            if (q.sr[7:4] == DEV_TYPE && q.sr[3:1] == strap_i && !ack_veto_i) begin
                                d.ack = 1'b1;
                                d.nxt = q.sr[0] ? S_RDATA : S_WADDR;
                            end
                        end else if (q.st == S_WADDR) begin
                            d.ptr = q.sr;
                            d.vld = '0;
                            if (!ack_veto_i) begin
                                d.ack = 1'b1;
                                d.nxt = S_WDATA;
                            end
                        end else begin
                            if (!wp_i && !q.wp_hit && !d.wp_hit && prot_allow_i && !ack_veto_i) begin
                                d.ack = 1'b1;
                                d.nxt = S_WDATA;
                                d.pbuf[q.ptr[PAGE_W-1:0]] = q.sr;
                                d.vld[q.ptr[PAGE_W-1:0]]  = 1'b1;
                                d.ptr[PAGE_W-1:0]         = q.ptr[PAGE_W-1:0] + PAGE_W'(1);
                            end
                        end
                    end
                end
                S_ACK: begin
                    if (scl_fall) begin
                        d.st  = q.nxt;
                        d.cnt = '0;
                        if (q.nxt == S_RDATA) begin
                            d.tx  = rd_data;
                            d.ptr = q.ptr + ADDR_W'(1);
                        end
                    end
                end
                S_RDATA: begin
                    if (scl_fall) begin
                        d.tx = {q.tx[6:0], 1'b1};
                        if (q.cnt == 4'd7) begin
                            d.cnt = '0;
                            d.st  = S_RACK;
                        end else begin
                            d.cnt = q.cnt + 4'd1;
                        end
                    end
                end
                S_RACK: begin
                    if (scl_rise) d.mack = !sda_s;
                    if (scl_fall) begin
                        if (q.mack) begin
                            d.tx  = rd_data;
                            d.ptr = q.ptr + ADDR_W'(1);
                            d.st  = S_RDATA;
                        end else begin
                            d.st = S_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= S_IDLE;
            q.nxt  <= S_IDLE;
            q.tx   <= 8'hFF;
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o    = (q.st == S_ACK && q.ack) || (q.st == S_RDATA && !q.tx[7]);
    assign busy_o      = (q.busy != '0);
    assign prot_addr_o = q.ptr;
endmodule

// File: rtl/eeprom_slave_chk.sv
module eeprom_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_s,
    input logic stop_evt,
    input logic sda_oe_o,
    input logic busy_o,
    input logic wp_i,
    input logic lowvcc_i
);
    AST_QUIET_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !sda_oe_o); // R5

    AST_DRIVE_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_s); // R3

    AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(stop_evt)); // R4

    AST_WP_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && wp_i) |=> !busy_o); // R10

    AST_LOWVCC_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> !$past(lowvcc_i)); // R12
endmodule

bind i2c_eeprom_slave eeprom_slave_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .stop_evt (stop_evt),
    .sda_oe_o (sda_oe_o),
    .busy_o   (busy_o),
    .wp_i     (wp_i),
    .lowvcc_i (lowvcc_i)
);

// File: tb/sim_i2c_eeprom_slave.sv
`timescale 1ns/1ps
module sim_i2c_eeprom_slave;
    localparam int WR = 100;
    localparam int Q  = 6;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] DEVW = {4'b1010, STRAP, 1'b0};
    localparam logic [7:0] DEVR = {4'b1010, STRAP, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic wp = 1'b0;
    logic lowvcc = 1'b0;
    logic allow = 1'b1;
    logic veto = 1'b0;
    logic sda_oe, busy;
    logic [7:0] paddr;
    logic sda_bus;

    int nchk = 0;
    int nfail = 0;
    int run = 0;
    int busy_len = 0;
    logic [7:0] exp_mem [256];

    assign sda_bus = sda_m & ~sda_oe;

    always #2 clk = ~clk;

    i2c_eeprom_slave #(.WR_CYCLES(WR)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl),
        .sda_i        (sda_bus),
        .strap_i      (STRAP),
        .wp_i         (wp),
        .lowvcc_i     (lowvcc),
        .prot_allow_i (allow),
        .ack_veto_i   (veto),
        .sda_oe_o     (sda_oe),
        .busy_o       (busy),
        .prot_addr_o  (paddr)
    );

    always @(negedge clk) begin
        if (busy) run <= run + 1;
        else if (run != 0) begin
            busy_len <= run;
            run <= 0;
        end
    end

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int expv);
        nchk++;
        if (act != expv) begin
            nfail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
        end
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; wt(Q);
        scl = 1'b1;   wt(Q);
        sda_m = 1'b0; wt(Q);
        scl = 1'b0;   wt(Q);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; wt(Q);
        scl = 1'b1;   wt(Q);
        sda_m = 1'b1; wt(Q);
    endtask

    task automatic bit_out(input logic b);
        sda_m = b; wt(Q);
        scl = 1'b1; wt(2 * Q);
        scl = 1'b0; wt(Q);
    endtask

    task automatic bit_in(output logic b);
        sda_m = 1'b1; wt(Q);
        scl = 1'b1; wt(Q);
        b = sda_bus; wt(Q);
        scl = 1'b0; wt(Q);
    endtask

    task automatic send(input logic [7:0] v, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) bit_out(v[i]);
        bit_in(a);
        ack = ~a;
    endtask

    task automatic recv(output logic [7:0] v, input logic more);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            bit_in(b);
            v[i] = b;
        end
        bit_out(~more);
    endtask

    task automatic wait_idle();
        while (busy) wt(1);
        wt(4);
    endtask

    task automatic rd_seq(input logic [7:0] a, input int n, input string tag);
        logic ack;
        logic [7:0] v;
        i2c_start();
        send(DEVW, ack);
        send(a, ack);
        i2c_start();
        send(DEVR, ack);
        chk({tag, " read ack"}, ack, 1);
        for (int k = 0; k < n; k++) begin
            recv(v, k != n - 1);
            chk(tag, v, exp_mem[8'(a + k)]);
        end
        i2c_stop();
    endtask

    task automatic wr_byte(input logic [7:0] a, input logic [7:0] v, output logic dack);
        logic ack;
        i2c_start();
        send(DEVW, ack);
        send(a, ack);
        send(v, dack);
        i2c_stop();
    endtask

    initial begin
        repeat (195000) @(negedge clk);
        nfail++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        logic ack;
        logic b;
        logic [7:0] v;
        for (int i = 0; i < 256; i++) exp_mem[i] = 8'hFF;
        wt(5);
        rst_n = 1'b1;
        wt(5);

        // R1: reset state
        chk("R1 sda_oe", sda_oe, 0);
        chk("R1 busy", busy, 0);
        rd_seq(8'h10, 1, "R1 init");
        rd_seq(8'hFF, 1, "R1 init top");

        // R2: address decode
        i2c_start(); send({4'b1010, 3'b011, 1'b0}, ack); i2c_stop();
        chk("R2 wrong strap", ack, 0);
        i2c_start(); send({4'b0110, STRAP, 1'b0}, ack); i2c_stop();
        chk("R2 wrong type", ack, 0);
        i2c_start(); send(DEVW, ack); i2c_stop();
        chk("R2 match", ack, 1);

        // R3 R4 R5: byte write, busy window, polling
        i2c_start();
        send(DEVW, ack); chk("R3 dev ack", ack, 1);
        send(8'h20, ack); chk("R3 addr ack", ack, 1);
        send(8'h5A, ack); chk("R3 data ack", ack, 1);
        i2c_stop();
        exp_mem[8'h20] = 8'h5A;
        wt(5);
        chk("R4 busy after stop", busy, 1);
        i2c_start(); send(DEVW, ack); i2c_stop();
        chk("R5 poll nack", ack, 0);
        wait_idle();
        chk("R4 busy length", busy_len, WR);
        rd_seq(8'h20, 1, "R3 R4 readback");

        // R8: current read continues at last address plus one
        i2c_start(); send(DEVR, ack); recv(v, 1'b0); i2c_stop();
        chk("R8 current 1", v, exp_mem[8'h21]);
        i2c_start(); send(DEVR, ack); recv(v, 1'b0); i2c_stop();
        chk("R8 current 2", v, exp_mem[8'h22]);

        // R6: page writes with wrap and overwrite on every page
        for (int p = 0; p < 16; p++) begin
            i2c_start();
            send(DEVW, ack);
            send(8'(p * 16 + 5), ack);
            for (int k = 0; k < 18; k++) begin
                v = 8'((p * 16 + k) * 29 + 7);
                send(v, ack);
                exp_mem[8'(p * 16 + ((5 + k) % 16))] = v;
            end
            i2c_stop();
            wait_idle();
        end
        // R7: sequential read across all locations and the wrap to zero
        rd_seq(8'h00, 257, "R6 R7 sweep");

        // R9: master nack stops output
        i2c_start(); send(DEVW, ack); send(8'h40, ack);
        i2c_start(); send(DEVR, ack); recv(v, 1'b0);
        chk("R9 data", v, exp_mem[8'h40]);
        wt(2);
        chk("R9 released", sda_oe, 0);
        bit_in(b);
        chk("R9 no more data", b, 1);
        i2c_stop();

        // R10: WP during data byte
        i2c_start(); send(DEVW, ack); send(8'h30, ack);
        wp = 1'b1;
        send(8'h11, ack);
        chk("R10 data nack", ack, 0);
        i2c_stop();
        wp = 1'b0;
        wt(5);
        chk("R10 no busy", busy, 0);
        rd_seq(8'h30, 1, "R10 unchanged");
        // R10: WP before the first data bit is ignored
        i2c_start(); send(DEVW, ack);
        wp = 1'b1;
        send(8'h31, ack);
        wp = 1'b0;
        send(8'h22, ack);
        chk("R10 early wp ignored", ack, 1);
        i2c_stop();
        exp_mem[8'h31] = 8'h22;
        wait_idle();
        rd_seq(8'h31, 1, "R10 early wp write");
        // R10: WP during the busy window
        wr_byte(8'h32, 8'h33, ack);
        wt(10);
        chk("R10 busy before abort", busy, 1);
        wp = 1'b1;
        wt(3);
        chk("R10 abort busy", busy, 0);
        wp = 1'b0;
        wt(3);
        rd_seq(8'h32, 1, "R10 abort keeps data");

        // R11: START then STOP cancels
        i2c_start(); send(DEVW, ack); send(8'h34, ack); send(8'h44, ack);
        i2c_start();
        i2c_stop();
        wt(5);
        chk("R11 no busy", busy, 0);
        rd_seq(8'h34, 1, "R11 unchanged");

        // R12: low supply at STOP
        lowvcc = 1'b1;
        wr_byte(8'h35, 8'h55, ack);
        wt(5);
        chk("R12 no busy", busy, 0);
        lowvcc = 1'b0;
        rd_seq(8'h35, 1, "R12 unchanged");

        // R13: per-byte permission and acknowledge veto
        allow = 1'b0;
        wr_byte(8'h36, 8'h66, ack);
        chk("R13 disallowed nack", ack, 0);
        allow = 1'b1;
        wt(5);
        chk("R13 no busy", busy, 0);
        rd_seq(8'h36, 1, "R13 unchanged");
        veto = 1'b1;
        i2c_start(); send(DEVW, ack); i2c_stop();
        chk("R13 veto", ack, 0);
        veto = 1'b0;

        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule